// File: doc/BRIEF.md
# Hot-Plug Slot Command and Event Register Unit

This unit holds the slot command word and the slot event word of a downstream port that accepts hot-plugged devices. Software reads and writes both words over a small register bus. Each write to the command word counts as one command. The command word drives the power switch, the power lamp and the attention lamp. Each command also reports its completion in the event word. The event word collects button presses, presence changes and command completions. Software clears these bits by writing ones to them.

The unit turns the enabled event bits into one pending summary. The summary produces a notification only when its value changes. In message mode that notification is a one-cycle request pulse; otherwise it is a level interrupt. When software powers off a populated slot and sets its lamp to the off code, the unit raises a detach pulse for that slot. It does this only when the command newly makes the off condition true.

The register bus has no back-pressure. A write is applied on the clock edge where `reg_wr` is sampled high. A read returns data in the same cycle from `reg_addr`. No data stream crosses the unit's edge, so it has no valid/ready handshake.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While `rst_n` is low, the command word becomes enables 0, attention lamp code 11 (off) in bits 7:6 and interlock control 0. A populated slot (`dev_present`=1) gets power lamp 01 (on) in bits 9:8 and power switch bit 10 = 0, so the word reads 0x01C0. An empty slot gets lamp 11 and switch 1, so the word reads 0x07C0. The event word reads 0x0040 if populated and 0x0000 if empty.
- R2: Address 0 reads the command word and address 1 reads the event word. Other addresses read 0. Command bits 0..5 are the enables for button, power fault, latch change, presence change, command done and the master interrupt enable. `pwr_off`, `pwr_ind` and `attn_ind` mirror bits 10, 9:8 and 7:6. Each byte of a write is applied only under its byte enable.
- R3: Any write to address 0 with at least one byte enabled sets event bit 4 (command done) in the same update.
- R4: Writing 1 to command bit 11 flips event bit 7 (interlock state). Command bit 11 always reads 0.
- R5: A command write raises `detach_req` for one cycle when three things hold: event bit 6 (presence) is 1, the new word has bit 10 = 1 and lamp code 11, and the old word did not already meet that off condition. The same update clears bit 6 and sets bit 3 (presence changed).
- R6: Event bits 0..4 are cleared by writing 1 to them under byte enable 0. If such a write targets an event bit that is currently 0, all five event bits keep their prior values.
- R7: The summary is bit 5 AND the OR over (event bits 0..4 AND command bits 0..4). With `msg_en`=0, `irq_level` takes the new summary value whenever the summary changes. With `msg_en`=1, `irq_level` holds.
- R8: With `msg_en`=1, `msg_req` pulses for one cycle when a command write or an event changes the summary. Setting an event bit that is already 1 gives no pulse.
- R9: A rising edge on `dev_present` after reset sets event bit 6 and sets bits 3 and 0. A device that is already present during reset sets bit 6 with no event bits.
- R10: A pulse on `attn_btn` sets event bit 0.
- R11: A write to the event word re-evaluates the summary without a message pulse. With `msg_en`=0, `irq_level` falls when the summary becomes false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address (0 command, 1 events) |
| reg_be | input | 2 | Byte enables for a write |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| dev_present | input | 1 | Device-present level from the slot |
| attn_btn | input | 1 | Attention button pulse |
| msg_en | input | 1 | 1: notify by message pulse, 0: by level interrupt |
| irq_level | output | 1 | Level interrupt |
| msg_req | output | 1 | One-cycle message request |
| detach_req | output | 1 | One-cycle request to detach the slot's device |
| pwr_off | output | 1 | Power switch command, 1 = off |
| pwr_ind | output | 2 | Power lamp code |
| attn_ind | output | 2 | Attention lamp code |

## Verification
Directed sequences cover several cases: a populated and an empty reset, an interlock flip, and a stray clear that must be undone next to a real clear. They also repeat a command to show that an already-set done bit stays silent. The off command is issued both as a fresh transition and as a repeat after a hot add, which separates edge-triggered detach from level-triggered detach. Seeded random mixes of byte-masked commands, clears, button presses, presence toggles and mode flips are then checked against a bench model. These mixes show whether message and level notifications follow summary changes rather than event arrivals.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  // command word fields
  localparam int C_EN_ABP  = 0;
  localparam int C_EN_PDC  = 3;
  localparam int C_EN_CC   = 4;
  localparam int C_HPIE    = 5;
  localparam int C_AIND    = 6;
  localparam int C_PIND    = 8;
  localparam int C_PCTL    = 10;
  localparam int C_ILCK    = 11;
  // event word fields
  localparam int S_ABP     = 0;
  localparam int S_PF      = 1;
  localparam int S_LC      = 2;
  localparam int S_PDC     = 3;
  localparam int S_CC      = 4;
  localparam int S_PDS     = 6;
  localparam int S_ILS     = 7;
  localparam int NUM_EVT   = 5;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;

  function automatic logic off_cond(input logic [15:0] c);
    return c[C_PCTL] && (c[C_PIND+:2] == IND_OFF);
  endfunction
endpackage

// File: rtl/hp_slot_cmd.sv
module hp_slot_cmd
  import hp_slot_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HAS_PWR_CTL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                populated,
  input  logic                wr_ctl,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                pds_q,
  output logic [DATA_W-1:0]   ctl_q,
  output logic [DATA_W-1:0]   ctl_next,
  output logic                cmd_pulse,
  output logic                ilck_flip,
  output logic                detach_now,
  output logic                detach_req
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [DATA_W-1:0] WMASK =
    (HAS_PWR_CTL != 0) ? DATA_W'(16'h07FF) : DATA_W'(16'h03FF);

  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] rst_val;

  for (genvar b = 0; b < BE_W; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{be[b]}};
  end

  if (HAS_PWR_CTL != 0) begin : g_pwr
    always_comb begin
      rst_val               = '0;
      rst_val[C_AIND +: 2]  = IND_OFF;
      rst_val[C_PIND +: 2]  = populated ? IND_ON : IND_OFF;
      rst_val[C_PCTL]       = ~populated;
    end
  end else begin : g_nopwr
    always_comb begin
      rst_val               = '0;
      rst_val[C_AIND +: 2]  = IND_OFF;
    end
  end

  always_comb begin
    ctl_next   = ctl_q;
    ilck_flip  = 1'b0;
    detach_now = 1'b0;
    if (wr_ctl) begin
      ctl_next   = (ctl_q & ~(bmask & WMASK)) | (wdata & bmask & WMASK);
      ilck_flip  = be[C_ILCK/8] & wdata[C_ILCK];
      detach_now = pds_q && off_cond(ctl_next) && !off_cond(ctl_q);
    end
  end

  assign cmd_pulse = wr_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= rst_val;
      detach_req <= 1'b0;
    end else begin
      ctl_q      <= ctl_next;
      detach_req <= detach_now;
    end
  end

  // R5: a detach request needs the off condition to be newly reached
  p_detach_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    detach_req |-> (off_cond(ctl_q) && !off_cond($past(ctl_q))));
  // R4: interlock control never reads back as one
  p_ilck_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctl) |-> !ctl_q[C_ILCK]);
endmodule

// File: rtl/hp_slot_evt.sv
module hp_slot_evt
  import hp_slot_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dev_present,
  input  logic               attn_btn,
  input  logic               wr_sta,
  input  logic               be_lo,
  input  logic [NUM_EVT-1:0] clr_bits,
  input  logic               cmd_pulse,
  input  logic               ilck_flip,
  input  logic               detach_now,
  output logic [DATA_W-1:0]  sta_q,
  output logic [NUM_EVT-1:0] ev_next,
  output logic               pds_q,
  output logic               quiet
);
  logic [NUM_EVT-1:0] ev_q, clr, ev_base, sets;
  logic ils_q, prev_q, hot_add, stray, pds_next, ils_next;

  always_comb begin
    clr      = (wr_sta && be_lo) ? clr_bits : '0;
    stray    = |(clr & ~ev_q);
    ev_base  = stray ? ev_q : (ev_q & ~clr);
    hot_add  = dev_present & ~prev_q;
    sets            = '0;
    sets[S_ABP]     = attn_btn | hot_add;
    sets[S_PDC]     = hot_add | detach_now;
    sets[S_CC]      = cmd_pulse;
    ev_next  = ev_base | sets;
    pds_next = hot_add ? 1'b1 : (detach_now ? 1'b0 : pds_q);
    ils_next = ils_q ^ ilck_flip;
    quiet    = wr_sta & ~attn_btn & ~hot_add;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      ils_q  <= 1'b0;
      pds_q  <= dev_present;
      prev_q <= dev_present;
    end else begin
      ev_q   <= ev_next;
      ils_q  <= ils_next;
      pds_q  <= pds_next;
      prev_q <= dev_present;
    end
  end

  always_comb begin
    sta_q                = '0;
    sta_q[NUM_EVT-1:0]   = ev_q;
    sta_q[S_PDS]         = pds_q;
    sta_q[S_ILS]         = ils_q;
  end

  // R3: a command leaves the done bit set
  p_cmd_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |=> sta_q[S_CC]);
  // R4: interlock state flips after a control write of one
  p_ilck_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ilck_flip |=> (sta_q[S_ILS] != $past(sta_q[S_ILS])));
  // R5: detach drops presence and flags a presence change
  p_detach_pres_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (detach_now && !hot_add) |=> (!pds_q && ev_q[S_PDC]));
  // R6: a stray clear leaves every event bit as it was
  p_stray_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stray && !attn_btn && !hot_add && !cmd_pulse && !detach_now) |=> (ev_q == $past(ev_q)));
endmodule

// File: rtl/hp_slot_irq.sv
module hp_slot_irq
  import hp_slot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_en,
  input  logic [C_HPIE:0]    ctl_next,
  input  logic [NUM_EVT-1:0] ev_next,
  input  logic               quiet,
  output logic               irq_level,
  output logic               msg_req
);
  logic summ_q, summ_next, changed;

  assign summ_next = ctl_next[C_HPIE] && |(ctl_next[NUM_EVT-1:0] & ev_next);
  assign changed   = summ_next != summ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      summ_q    <= 1'b0;
      irq_level <= 1'b0;
      msg_req   <= 1'b0;
    end else begin
      summ_q  <= summ_next;
      msg_req <= changed && !quiet && msg_en;
      if (changed && !msg_en) irq_level <= summ_next;
    end
  end

  // R8: a message only accompanies a summary change
  p_msg_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (summ_q != $past(summ_q)));
  // R7: in message mode the level output holds
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_en) |-> $stable(irq_level));
  // R11: the level only falls once the summary is false
  p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_level) |-> !summ_q);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int CTL_ADDR    = 0,
  parameter int STA_ADDR    = 1,
  parameter int HAS_PWR_CTL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W/8-1:0] reg_be,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_wr,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                dev_present,
  input  logic                attn_btn,
  input  logic                msg_en,
  output logic                irq_level,
  output logic                msg_req,
  output logic                detach_req,
  output logic                pwr_off,
  output logic [1:0]          pwr_ind,
  output logic [1:0]          attn_ind
);
  logic wr_ctl, wr_sta, cmd_pulse, ilck_flip, detach_now, pds_q, quiet;
  logic [DATA_W-1:0] ctl_q, ctl_next, sta_q;
  logic [NUM_EVT-1:0] ev_next;

  assign wr_ctl = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR)) && |reg_be;
  assign wr_sta = reg_wr && (reg_addr == ADDR_W'(STA_ADDR)) && |reg_be;

  hp_slot_cmd #(.DATA_W(DATA_W), .HAS_PWR_CTL(HAS_PWR_CTL)) u_cmd (
    .clk(clk), .rst_n(rst_n), .populated(dev_present), .wr_ctl(wr_ctl),
    .be(reg_be), .wdata(reg_wdata), .pds_q(pds_q), .ctl_q(ctl_q),
    .ctl_next(ctl_next), .cmd_pulse(cmd_pulse), .ilck_flip(ilck_flip),
    .detach_now(detach_now), .detach_req(detach_req)
  );

  hp_slot_evt #(.DATA_W(DATA_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .dev_present(dev_present), .attn_btn(attn_btn),
    .wr_sta(wr_sta), .be_lo(reg_be[0]), .clr_bits(reg_wdata[NUM_EVT-1:0]),
    .cmd_pulse(cmd_pulse), .ilck_flip(ilck_flip), .detach_now(detach_now),
    .sta_q(sta_q), .ev_next(ev_next), .pds_q(pds_q), .quiet(quiet)
  );

  hp_slot_irq u_irq (
    .clk(clk), .rst_n(rst_n), .msg_en(msg_en), .ctl_next(ctl_next[C_HPIE:0]),
    .ev_next(ev_next), .quiet(quiet), .irq_level(irq_level), .msg_req(msg_req)
  );

  always_comb begin
    if (reg_addr == ADDR_W'(CTL_ADDR))      reg_rdata = ctl_q;
    else if (reg_addr == ADDR_W'(STA_ADDR)) reg_rdata = sta_q;
    else                                    reg_rdata = '0;
  end

  assign pwr_off  = ctl_q[C_PCTL];
  assign pwr_ind  = ctl_q[C_PIND +: 2];
  assign attn_ind = ctl_q[C_AIND +: 2];

  // R9: a hot add shows presence with a change event on the next cycle
  p_hot_add_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_present && !$past(dev_present) && !detach_now) |=> (sta_q[S_PDS] && sta_q[S_PDC]));
endmodule

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0, msg_en = 1'b0, dev_present = 1'b1, attn_btn = 1'b0;
  logic [1:0] reg_addr = '0, reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq_level, msg_req, detach_req, pwr_off;
  logic [1:0] pwr_ind, attn_ind;

  hp_slot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .dev_present(dev_present), .attn_btn(attn_btn), .msg_en(msg_en),
    .irq_level(irq_level), .msg_req(msg_req), .detach_req(detach_req),
    .pwr_off(pwr_off), .pwr_ind(pwr_ind), .attn_ind(attn_ind)
  );

  int checks = 0, fails = 0;
  logic [15:0] m_ctl;
  logic [4:0]  m_ev;
  logic m_pds, m_ils, m_prev, m_sum, m_irq;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_sta();
    return {8'h00, m_ils, m_pds, 1'b0, m_ev};
  endfunction

  function automatic logic off_c(input logic [15:0] c);
    return c[10] && (c[9:8] == 2'b11);
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    return (a == 2'd0) ? m_ctl : (a == 2'd1) ? m_sta() : 16'h0000;
  endfunction

  // one clock: drive at negedge, predict, compare after the edge
  task automatic cyc(input bit w, input logic [1:0] a, input logic [1:0] be,
                     input logic [15:0] d, input bit btn, input bit pres);
    logic [15:0] bm, nctl, wm;
    logic [4:0] ev, clr;
    logic wc, ws, flip, det, hadd, pds, sum, quiet, e_msg;
    reg_wr = w; reg_addr = a; reg_be = be; reg_wdata = d; attn_btn = btn; dev_present = pres;
    #2;
    if (!w) chk("R2 read", reg_rdata, m_read(a));
    bm   = {{8{be[1]}}, {8{be[0]}}};
    wc   = w && a == 2'd0 && |be;
    ws   = w && a == 2'd1 && |be;
    nctl = m_ctl; flip = 1'b0; det = 1'b0;
    if (wc) begin
      wm   = bm & 16'h07FF;
      nctl = (m_ctl & ~wm) | (d & wm);
      flip = be[1] & d[11];
      det  = m_pds && off_c(nctl) && !off_c(m_ctl);
    end
    ev = m_ev;
    if (ws) begin
      clr = d[4:0] & {5{be[0]}};
      if ((clr & ~ev) == 5'b0) ev = ev & ~clr;
    end
    hadd = pres && !m_prev;
    if (btn || hadd) ev[0] = 1'b1;
    if (hadd || det) ev[3] = 1'b1;
    if (wc) ev[4] = 1'b1;
    pds   = hadd ? 1'b1 : (det ? 1'b0 : m_pds);
    sum   = nctl[5] && |(nctl[4:0] & ev);
    quiet = ws && !btn && !hadd;
    e_msg = (sum != m_sum) && !quiet && msg_en;
    if (sum != m_sum && !msg_en) m_irq = sum;
    m_ctl = nctl; m_ev = ev; m_pds = pds; m_ils = m_ils ^ flip; m_prev = pres; m_sum = sum;
    @(posedge clk);
    @(negedge clk);
    chk("R8 msg_req", {15'b0, msg_req}, {15'b0, e_msg});
    chk("R7 irq_level", {15'b0, irq_level}, {15'b0, m_irq});
    chk("R5 detach_req", {15'b0, detach_req}, {15'b0, det});
    chk("R2 slot outputs", {11'b0, pwr_off, pwr_ind, attn_ind}, {11'b0, m_ctl[10], m_ctl[9:8], m_ctl[7:6]});
    reg_wr = 1'b0; attn_btn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc(1'b1, a, 2'b11, d, 1'b0, dev_present);
  endtask

  task automatic rdchk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_wr = 1'b0; reg_addr = a;
    #2;
    chk(tag, reg_rdata, exp);
    cyc(1'b0, a, 2'b00, 16'h0, 1'b0, dev_present);
  endtask

  task automatic do_reset(input bit pres);
    @(negedge clk);
    rst_n = 1'b0; dev_present = pres; reg_wr = 1'b0; attn_btn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_ctl = pres ? 16'h01C0 : 16'h07C0;
    m_ev = '0; m_pds = pres; m_ils = 1'b0; m_prev = pres; m_sum = 1'b0; m_irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5107_C0DE));
    // R1 populated reset, R9 no event at boot
    do_reset(1'b1);
    chk("R1 irq after reset", {15'b0, irq_level}, 16'h0);
    rdchk("R1 ctl populated", 2'd0, 16'h01C0);
    rdchk("R9 boot presence no event", 2'd1, 16'h0040);
    rdchk("R2 unused address", 2'd2, 16'h0000);
    // R4 interlock flip, R3 command done
    wr(2'd0, 16'h09C0);
    rdchk("R4 control bit reads zero", 2'd0, 16'h01C0);
    rdchk("R4 R3 interlock and done", 2'd1, 16'h00D0);
    // R6 stray clear restores, real clear works
    wr(2'd1, 16'h0002);
    rdchk("R6 stray clear restored", 2'd1, 16'h00D0);
    wr(2'd1, 16'h0010);
    rdchk("R6 done cleared", 2'd1, 16'h00C0);
    // R7 level interrupt
    wr(2'd0, 16'h01F0);
    chk("R7 irq rises", {15'b0, irq_level}, 16'h1);
    // R11 status write drops the level without message
    wr(2'd1, 16'h0010);
    chk("R11 irq falls", {15'b0, irq_level}, 16'h0);
    chk("R11 no message", {15'b0, msg_req}, 16'h0);
    // R8 message mode
    msg_en = 1'b1;
    wr(2'd0, 16'h01F0);
    chk("R8 message on rise", {15'b0, msg_req}, 16'h1);
    wr(2'd0, 16'h01F0);
    chk("R8 no message when already set", {15'b0, msg_req}, 16'h0);
    // R10 button
    cyc(1'b0, 2'd1, 2'b00, 16'h0, 1'b1, 1'b1);
    rdchk("R10 button event", 2'd1, 16'h00D1);
    // R5 detach on new off condition
    wr(2'd0, 16'h07F0);
    chk("R5 detach fires", {15'b0, detach_req}, 16'h1);
    rdchk("R5 presence dropped", 2'd1, 16'h0099);
    // R9 hot add
    cyc(1'b0, 2'd1, 2'b00, 16'h0, 1'b0, 1'b0);
    cyc(1'b0, 2'd1, 2'b00, 16'h0, 1'b0, 1'b1);
    rdchk("R9 hot add", 2'd1, 16'h00D9);
    wr(2'd0, 16'h07F0);
    chk("R5 repeated off no detach", {15'b0, detach_req}, 16'h0);
    wr(2'd0, 16'h01F0);
    wr(2'd0, 16'h07F0);
    chk("R5 detach after power on", {15'b0, detach_req}, 16'h1);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [1:0] be;
      op = $urandom % 8;
      be = 2'($urandom % 3 + 1);
      case (op)
        0, 1: cyc(1'b1, 2'd0, be, 16'($urandom) & 16'h0FFF, 1'b0, dev_present);
        2:    cyc(1'b1, 2'd1, be, 16'($urandom) & 16'h001F, 1'b0, dev_present);
        3:    cyc(1'b0, 2'($urandom), 2'b00, 16'h0, 1'b1, dev_present);
        4:    cyc(1'b0, 2'($urandom), 2'b00, 16'h0, 1'b0, ~dev_present);
        5:    begin msg_en = ~msg_en; cyc(1'b0, 2'd1, 2'b00, 16'h0, 1'b0, dev_present); end
        default: cyc(1'b0, 2'($urandom), 2'b00, 16'h0, 1'b0, dev_present);
      endcase
    end
    // R1 empty slot reset
    msg_en = 1'b0;
    do_reset(1'b0);
    rdchk("R1 ctl empty", 2'd0, 16'h07C0);
    rdchk("R1 status empty", 2'd1, 16'h0000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule